// File: doc/BRIEF.md
# Asynchronous SRAM Write-Strobe Sequencer

This block is a synchronous controller for an external asynchronous static RAM. Requests arrive on a valid/ready interface that carries a write flag, an address and write data. The controller turns each request into pin-level activity on the memory's chip-select, read/write and output-enable lines. It also drives the enable of its own half of the bidirectional data bus. Every timing interval is a whole number of system-clock cycles, and each interval is set by a parameter.

A write passes through five phases in order: address setup, strobe, data hold, address hold, and back to idle. One parameter picks which strobe ends the write. It is either the read/write line or the chip-select line, and the data-hold interval is counted from the rising edge of that line. A second parameter picks the output-enable policy during writes:

- Output-enable held high: the strobe is as short as the minimum write pulse.
- Output-enable left low: the strobe is lengthened. The memory's output drivers then have time to turn off before write data is driven, and the data setup time is still met.

A read holds chip-select and output-enable low with read/write high for an access interval. It samples the data bus and returns the word on a one-cycle response strobe. A guard counter keeps every operation at or above a minimum total cycle length before the next request is taken.

Top module: `sram_strobe_seq`

## Requirements
- R1: A write happens only while `sram_cs_n` and `sram_we_n` are both low.
  - With `CS_ENDS_WRITE`=0, `sram_cs_n` is low through setup, strobe and data hold, and `sram_we_n` is low only during the strobe.
  - With `CS_ENDS_WRITE`=1, `sram_cs_n` is low only during the strobe, and `sram_we_n` is low through strobe and data hold.
  - Both lines are high during address hold.
- R2: After the rising edge of the strobe that ends a write, `sram_dq_oe` stays high and `sram_dq_out` stays unchanged for `HOLD_CYC` cycles.
- R3: `sram_addr` changes only in a cycle where `sram_we_n` is high in both that cycle and the one before. A new address appears in the first setup cycle after a request is accepted, and it holds until the next acceptance.
- R4: With `OE_HELD_HIGH`=0:
  - `sram_oe_n` is low during setup and strobe.
  - The strobe lasts max(`PULSE_MIN`, `DRV_OFF`+`DSETUP`) cycles.
  - `sram_dq_oe` rises only once the strobe has lasted `DRV_OFF` cycles.
- R5: With `OE_HELD_HIGH`=1:
  - `sram_oe_n` stays high for the whole write.
  - The strobe lasts max(`PULSE_MIN`, `DSETUP`) cycles.
  - `sram_dq_oe` is high from the first strobe cycle.
- R6: The write phases run in the order setup (`SETUP_CYC` cycles), strobe, data hold (`HOLD_CYC`), address hold (`AHOLD_CYC`), idle. Counting starts in the cycle after the accepting clock edge.
- R7: `req_ready` falls after an accepted request. It returns only after `CYCLE_MIN` cycles have passed since that acceptance, so two acceptances are never closer than `CYCLE_MIN` cycles. A request held valid in the meantime is not taken early.
- R8: A read holds `sram_cs_n` and `sram_oe_n` low and `sram_we_n` high for `ACCESS_CYC` cycles, with `sram_dq_oe` low throughout. `sram_dq_in` is sampled in the last access cycle. `rsp_valid` is high for exactly the next cycle, with `rsp_rdata` carrying the sampled word, and all strobes are high in that cycle.
- R9: While `rst` is high:
  - `sram_cs_n`, `sram_we_n` and `sram_oe_n` are high.
  - `sram_dq_oe`, `rsp_valid` and `req_ready` are low.
  - `req_ready` is high in the first cycle after reset.
- R10: `sram_dq_oe` is never high while the memory may be driving the bus. The memory may drive when chip-select and output-enable are low and either read/write is high or read/write has been low for fewer than `DRV_OFF` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Memory address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DW | Read data |
| sram_addr | output | AW | Memory address pins |
| sram_cs_n | output | 1 | Chip-select, active low |
| sram_we_n | output | 1 | Read/write, low = write |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_dq_out | output | DW | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable for the controller's data drivers |
| sram_dq_in | input | DW | Data returned from the memory |

## Verification
The assertions check several rules on every cycle:

- The address never moves unless read/write has been high for two cycles.
- Data stays driven and unchanged in the cycle after the terminating edge.
- The controller's drivers are off at the start of a strobe taken with output-enable low.
- The drivers never overlap a memory read.
- Acceptance always drops `req_ready`.

Only the bench's scenarios show the full phase sequence and its lengths for both termination and output-enable policies, cycle by cycle, and the exact spacing of back-to-back acceptances. The same holds for the contention window just after read/write falls, and for the data actually stored in and read back from a behavioural memory.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_DHOLD  = 3'd3,
    PH_AHOLD  = 3'd4,
    PH_RACC   = 3'd5,
    PH_RREL   = 3'd6
  } phase_e;

  function automatic int unsigned smax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count,
  output logic [W-1:0] count_nxt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  // Saturating up-counter, cleared whenever the phase changes.
  always_comb begin
    if (restart)          count_nxt = '0;
    else if (count == TOP) count_nxt = count;
    else                  count_nxt = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

endmodule

// File: rtl/sram_cycle_guard.sv
module sram_cycle_guard #(
  parameter int unsigned CYCLE_MIN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);

  localparam int GW = $clog2(CYCLE_MIN);
  localparam logic [GW-1:0] LAST = GW'(CYCLE_MIN - 1);

  logic [GW-1:0] cnt;

  // Zero means no operation is inside its minimum cycle window.
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= GW'(1);
    else if (cnt == LAST)  cnt <= '0;
    else if (cnt != '0)    cnt <= cnt + 1'b1;
  end

  assign done = (cnt == '0);

  AST_GUARD_START_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    start |-> done); // R7

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC     = 1,
  parameter int unsigned PULSE_MIN     = 3,
  parameter int unsigned DRV_OFF       = 2,
  parameter int unsigned DSETUP        = 2,
  parameter int unsigned HOLD_CYC      = 1,
  parameter int unsigned AHOLD_CYC     = 1,
  parameter int unsigned ACCESS_CYC    = 3,
  parameter bit          OE_HELD_HIGH  = 1'b0,
  parameter bit          CS_ENDS_WRITE = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   fire,
  input  logic   fire_write,
  output phase_e phase,
  output logic   cs_n,
  output logic   we_n,
  output logic   oe_n,
  output logic   dq_oe,
  output logic   capture
);

  localparam int unsigned PULSE_CYC = OE_HELD_HIGH ? smax(PULSE_MIN, DSETUP)
                                                   : smax(PULSE_MIN, DRV_OFF + DSETUP);
  localparam int unsigned MAXLEN = smax(smax(smax(SETUP_CYC, PULSE_CYC),
                                             smax(HOLD_CYC, AHOLD_CYC)),
                                        smax(ACCESS_CYC, DRV_OFF + 1));
  localparam int CW = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] DRV_IDX = CW'(DRV_OFF);

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt, cnt_n, last_idx;
  logic          last, restart;
  logic          cs_sel, we_sel, oe_wr, drv_strobe;

  always_comb begin
    case (ph_q)
      PH_SETUP:  last_idx = CW'(SETUP_CYC - 1);
      PH_STROBE: last_idx = CW'(PULSE_CYC - 1);
      PH_DHOLD:  last_idx = CW'(HOLD_CYC - 1);
      PH_AHOLD:  last_idx = CW'(AHOLD_CYC - 1);
      PH_RACC:   last_idx = CW'(ACCESS_CYC - 1);
      default:   last_idx = '0;
    endcase
  end

  assign last = (cnt == last_idx);

  always_comb begin
    ph_n = ph_q;
    case (ph_q)
      PH_IDLE:   if (fire) ph_n = fire_write ? PH_SETUP : PH_RACC;
      PH_SETUP:  if (last) ph_n = PH_STROBE;
      PH_STROBE: if (last) ph_n = PH_DHOLD;
      PH_DHOLD:  if (last) ph_n = PH_AHOLD;
      PH_AHOLD:  if (last) ph_n = PH_IDLE;
      PH_RACC:   if (last) ph_n = PH_RREL;
      PH_RREL:   ph_n = PH_IDLE;
      default:   ph_n = PH_IDLE;
    endcase
  end

  assign restart = (ph_n != ph_q);

  sram_phase_timer #(.W(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .count     (cnt),
    .count_nxt (cnt_n)
  );

  // Which strobe closes the write.
  generate
    if (CS_ENDS_WRITE) begin : g_cs_ends
      assign cs_sel = (ph_n == PH_STROBE);
      assign we_sel = (ph_n == PH_STROBE) || (ph_n == PH_DHOLD);
    end else begin : g_we_ends
      assign cs_sel = (ph_n == PH_SETUP) || (ph_n == PH_STROBE) || (ph_n == PH_DHOLD);
      assign we_sel = (ph_n == PH_STROBE);
    end
  endgenerate

  // Output-enable policy during writes and the matching driver turn-on point.
  generate
    if (OE_HELD_HIGH) begin : g_oe_high
      assign oe_wr      = 1'b0;
      assign drv_strobe = (ph_n == PH_STROBE);
    end else begin : g_oe_low
      assign oe_wr      = (ph_n == PH_SETUP) || (ph_n == PH_STROBE);
      assign drv_strobe = (ph_n == PH_STROBE) && (cnt_n >= DRV_IDX);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      cs_n  <= !(cs_sel || (ph_n == PH_RACC));
      we_n  <= !we_sel;
      oe_n  <= !(oe_wr || (ph_n == PH_RACC));
      dq_oe <= drv_strobe || (ph_n == PH_DHOLD);
    end
  end

  assign phase   = ph_q;
  assign capture = (ph_q == PH_RACC) && last;

  AST_NO_DRIVE_AT_STROBE_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(!cs_n && !we_n) && !oe_n) |-> !dq_oe); // R4

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_seq_pkg::*;
#(
  parameter int unsigned AW            = 8,
  parameter int unsigned DW            = 16,
  parameter int unsigned SETUP_CYC     = 1,
  parameter int unsigned PULSE_MIN     = 3,
  parameter int unsigned DRV_OFF       = 2,
  parameter int unsigned DSETUP        = 2,
  parameter int unsigned HOLD_CYC      = 1,
  parameter int unsigned AHOLD_CYC     = 1,
  parameter int unsigned ACCESS_CYC    = 3,
  parameter int unsigned CYCLE_MIN     = 10,
  parameter bit          OE_HELD_HIGH  = 1'b0,
  parameter bit          CS_ENDS_WRITE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  phase_e phase;
  logic   fire, guard_done, capture;

  assign req_ready = !rst && (phase == PH_IDLE) && guard_done;
  assign fire      = req_valid && req_ready;

  sram_cycle_guard #(.CYCLE_MIN(CYCLE_MIN)) u_guard (
    .clk   (clk),
    .rst   (rst),
    .start (fire),
    .done  (guard_done)
  );

  sram_seq_fsm #(
    .SETUP_CYC     (SETUP_CYC),
    .PULSE_MIN     (PULSE_MIN),
    .DRV_OFF       (DRV_OFF),
    .DSETUP        (DSETUP),
    .HOLD_CYC      (HOLD_CYC),
    .AHOLD_CYC     (AHOLD_CYC),
    .ACCESS_CYC    (ACCESS_CYC),
    .OE_HELD_HIGH  (OE_HELD_HIGH),
    .CS_ENDS_WRITE (CS_ENDS_WRITE)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .fire_write (req_write),
    .phase      (phase),
    .cs_n       (sram_cs_n),
    .we_n       (sram_we_n),
    .oe_n       (sram_oe_n),
    .dq_oe      (sram_dq_oe),
    .capture    (capture)
  );

  // Address and write data registers: loaded only on acceptance.
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (fire) begin
      sram_addr <= req_addr;
      if (req_write) sram_dq_out <= req_wdata;
    end
  end

  // Read capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= sram_dq_in;
    end
  end

  AST_ADDR_MOVES_ONLY_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n))); // R3

  AST_DATA_HELD_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (($rose(sram_we_n) && !$past(sram_cs_n)) || ($rose(sram_cs_n) && !$past(sram_we_n)))
      |-> (sram_dq_oe && $stable(sram_dq_out))); // R2

  AST_NO_BUS_FIGHT_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && !sram_oe_n && sram_we_n) |-> !sram_dq_oe); // R10

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R7

endmodule

// File: tb/tb_sram_strobe_seq.sv
`timescale 1ns/1ps
module tb_sram_strobe_seq;

  localparam int SU = 1, PMIN = 3, DOFF = 2, DSU = 2, HO = 1, AH = 1;
  localparam int ACC = 3, CMIN = 10;
  localparam int PA = (PMIN > DOFF + DSU) ? PMIN : DOFF + DSU; // OE low policy
  localparam int PB = (PMIN > DSU) ? PMIN : DSU;               // OE high policy

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;

  logic rdy_a, rv_a, cs_a, we_a, oe_a, doe_a;
  logic rdy_b, rv_b, cs_b, we_b, oe_b, doe_b;
  logic [15:0] rd_a, rd_b, dout_a, dout_b, din_a, din_b;
  logic [7:0]  ad_a, ad_b;

  int checks = 0, fails = 0, cyc = 0, cont_bad = 0;
  logic [15:0] mem_a [0:255];
  logic [15:0] mem_b [0:255];
  logic [15:0] sb [0:255];

  always #2.5 clk = ~clk;

  // dut: read/write ends the write, output-enable low during writes
  sram_strobe_seq #(.OE_HELD_HIGH(1'b0), .CS_ENDS_WRITE(1'b0)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_a),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_a), .rsp_rdata(rd_a), .sram_addr(ad_a), .sram_cs_n(cs_a),
    .sram_we_n(we_a), .sram_oe_n(oe_a), .sram_dq_out(dout_a),
    .sram_dq_oe(doe_a), .sram_dq_in(din_a));

  // dut_alt: chip-select ends the write, output-enable held high
  sram_strobe_seq #(.OE_HELD_HIGH(1'b1), .CS_ENDS_WRITE(1'b1)) dut_alt (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_b),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_b), .rsp_rdata(rd_b), .sram_addr(ad_b), .sram_cs_n(cs_b),
    .sram_we_n(we_b), .sram_oe_n(oe_b), .sram_dq_out(dout_b),
    .sram_dq_oe(doe_b), .sram_dq_in(din_b));

  // Behavioural memories
  assign din_a = (!cs_a && !oe_a && we_a) ? mem_a[ad_a] : 16'h0000;
  assign din_b = (!cs_b && !oe_b && we_b) ? mem_b[ad_b] : 16'h0000;

  logic act_a = 1'b0, act_b = 1'b0;
  int   wl_a = 0, wl_b = 0;
  always @(negedge clk) begin
    if (act_a && !(!cs_a && !we_a)) mem_a[ad_a] = doe_a ? dout_a : 16'hDEAD;
    if (act_b && !(!cs_b && !we_b)) mem_b[ad_b] = doe_b ? dout_b : 16'hDEAD;
    act_a = !cs_a && !we_a;
    act_b = !cs_b && !we_b;
    if (!rst) begin
      if (!cs_a && !oe_a && (we_a || wl_a < DOFF) && doe_a) cont_bad++;
      if (!cs_b && !oe_b && (we_b || wl_b < DOFF) && doe_b) cont_bad++;
    end
    wl_a = we_a ? 0 : wl_a + 1;
    wl_b = we_b ? 0 : wl_b + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!rdy_a) @(negedge clk);
  endtask

  task automatic test_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cs_a && we_a && oe_a && cs_b && we_b && oe_b, "R9", "strobes in reset",
          {cs_a, we_a, oe_a, cs_b, we_b, oe_b}, 6'h3f);
      chk(!doe_a && !doe_b && !rv_a && !rv_b, "R9", "drive/rsp in reset",
          {doe_a, doe_b, rv_a, rv_b}, 0);
      chk(!rdy_a && !rdy_b, "R9", "ready in reset", {rdy_a, rdy_b}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(rdy_a && rdy_b, "R9", "ready after reset", {rdy_a, rdy_b}, 2'b11);
  endtask

  task automatic test_write(input logic [7:0] a, input logic [15:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    for (int k = 0; k < CMIN; k++) begin
      bit ecs_a, ewe_a, eoe_a, edr_a, ecs_b, ewe_b, edr_b;
      @(negedge clk);
      ecs_a = (k < SU + PA + HO);
      ewe_a = (k >= SU) && (k < SU + PA);
      eoe_a = (k < SU + PA);
      edr_a = ((k >= SU + DOFF) && (k < SU + PA)) || ((k >= SU + PA) && (k < SU + PA + HO));
      ecs_b = (k >= SU) && (k < SU + PB);
      ewe_b = (k >= SU) && (k < SU + PB + HO);
      edr_b = (k >= SU) && (k < SU + PB + HO);
      chk(cs_a == !ecs_a && we_a == !ewe_a, "R1 R6", "dut cs_n/we_n", {cs_a, we_a}, {!ecs_a, !ewe_a});
      chk(cs_b == !ecs_b && we_b == !ewe_b, "R1 R6", "dut_alt cs_n/we_n", {cs_b, we_b}, {!ecs_b, !ewe_b});
      chk(oe_a == !eoe_a && doe_a == edr_a, "R4", "dut oe_n/dq_oe", {oe_a, doe_a}, {!eoe_a, edr_a});
      chk(oe_b && doe_b == edr_b, "R5", "dut_alt oe_n/dq_oe", {oe_b, doe_b}, {1'b1, edr_b});
      chk(ad_a == a && ad_b == a, "R3", "address held", {ad_a, ad_b}, {a, a});
      if (edr_a) chk(dout_a == d, "R2", "dut write data", dout_a, d);
      if (edr_b) chk(dout_b == d, "R2", "dut_alt write data", dout_b, d);
      chk(rdy_a == (k == CMIN - 1) && rdy_b == rdy_a, "R7", "ready window",
          {rdy_a, rdy_b}, {2{k == CMIN - 1}});
      if (k == 0) req_valid = 1'b0;
    end
    sb[a] = d;
  endtask

  task automatic test_read(input logic [7:0] a);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    for (int k = 0; k < CMIN; k++) begin
      @(negedge clk);
      if (k < ACC) begin
        chk(!cs_a && !oe_a && we_a && !doe_a, "R8", "dut read strobes",
            {cs_a, oe_a, we_a, doe_a}, 4'b0010);
        chk(!cs_b && !oe_b && we_b && !doe_b, "R8", "dut_alt read strobes",
            {cs_b, oe_b, we_b, doe_b}, 4'b0010);
      end else if (k == ACC) begin
        chk(rv_a && rd_a == sb[a], "R8", "dut read data", {rv_a, rd_a}, {1'b1, sb[a]});
        chk(rv_b && rd_b == sb[a], "R8", "dut_alt read data", {rv_b, rd_b}, {1'b1, sb[a]});
        chk(cs_a && oe_a && cs_b && oe_b, "R8", "release cycle", {cs_a, oe_a, cs_b, oe_b}, 4'hf);
      end else begin
        chk(!rv_a && !rv_b, "R8", "rsp_valid single cycle", {rv_a, rv_b}, 0);
      end
      chk(rdy_a == (k == CMIN - 1), "R7", "ready window on read", rdy_a, (k == CMIN - 1));
      if (k == 0) req_valid = 1'b0;
    end
  endtask

  task automatic test_spacing(input logic [7:0] a1, input logic [15:0] d1,
                              input logic [7:0] a2, input logic [15:0] d2);
    int gap = -1;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a1; req_wdata = d1;
    for (int i = 1; i <= CMIN + 2; i++) begin
      @(negedge clk);
      if (i == 1) begin req_addr = a2; req_wdata = d2; end
      if (i == 1) chk(ad_a == a1, "R3", "first address latched", ad_a, a1);
      if (rdy_a && gap < 0) gap = i;
      if (gap > 0 && i == gap + 1) req_valid = 1'b0;
    end
    chk(gap == CMIN, "R7", "back-to-back acceptance spacing", gap, CMIN);
    sb[a1] = d1; sb[a2] = d2;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_a[i] = '0; mem_b[i] = '0; sb[i] = '0;
    end
    test_reset();
    test_write(8'h00, 16'hFFFF);
    test_write(8'hFF, 16'hA5A5);
    test_write(8'h3C, 16'h1234);
    test_read(8'h00);
    test_read(8'hFF);
    test_read(8'h3C);
    test_write(8'h3C, 16'h5A5A);
    test_read(8'h3C);
    test_read(8'h10);
    test_spacing(8'h41, 16'h0F0F, 8'h42, 16'hF0F0);
    test_read(8'h41);
    test_read(8'h42);
    chk(cont_bad == 0, "R10", "bus contention cycles", cont_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule